// File: doc/BRIEF.md
# Segmented Data Memory Address Mapper

This block sits between an 8-bit processor's data port and a 512-byte physical RAM. An 8-bit data address reaches only 256 locations, so the lower half of that space (offsets 0x00–0x7F) is treated as a 128-byte window. The window is moved by a segment byte that software writes like any other location. The upper half (0x80–0xFF) is fixed. Its top sixteen bytes are a register bank that is always visible. The rest of the upper half goes to an external I/O port.

The register bank holds four pointer bytes at fixed addresses: X at 0xFC, the stack pointer at 0xFD, B at 0xFE and the segment byte at 0xFF. Accesses that the processor flags as stack traffic always land in segment 0, whatever the segment byte holds. Only segments 0–3 are populated. Segment 0 offsets 0x70–0x7F and every segment from 4 upward read as zero, and writes to them are discarded.

Top module: `seg_mem_mapper`

## Requirements
- R1: Addresses 0x80–0xFF are never relocated. A register byte at 0xF0–0xFF returns the same stored value for any segment byte value.
- R2: An access at address A with bit 7 clear, and without the stack flag, reaches physical location {S, A[6:0]}. Segments 1, 2 and 3 each hold 128 independent bytes.
- R3: The segment byte S is the register at 0xFF. A write there relocates the window from the very next access. No other access changes S.
- R4: After a synchronous reset, X (0xFC), B (0xFE) and S (0xFF) read 0x00, the stack pointer (0xFD) reads 0x6F, and cpu_rdata is 0x00.
- R5: In segment 0, offsets 0x70–0x7F read 0x00 and writes there have no effect.
- R6: With S at 4 or above, lower-half reads return 0x00. Writes there are discarded and do not alias into segments 0–3.
- R7: An access with cpu_stack high and address bit 7 clear uses segment 0 regardless of S, and it leaves S unchanged.
- R8: For addresses 0x80–0xEF, io_rd or io_wr follows the CPU strobe, with io_addr and io_wdata equal to the CPU values. A read returns io_rdata as sampled in the strobe cycle. No I/O strobe is raised for any other address.
- R9: Read data appears on cpu_rdata in the cycle after cpu_rd. It holds until the next read.
- R10: When cpu_rd and cpu_wr are both high for one address, the read returns the previous contents and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | CPU data address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_stack | input | 1 | Marks the access as stack traffic (forces segment 0) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one cycle after cpu_rd |
| io_addr | output | 8 | Address forwarded to the I/O port |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 8 | Data forwarded to the I/O port |
| io_rdata | input | 8 | I/O read data, valid in the strobe cycle |

## Verification
Two functions of this block can fall in the same cycle.

The first pair is a read and a write to one location: both strobes are high at once. The bench provokes this with directed cases in a populated segment and in the register bank, and with random traffic in which both strobes are often set together. It judges each case by requiring the old value on cpu_rdata and the new value on the following read.

The second pair is a write to the segment byte followed, with no gap, by a lower-half access. The bench expects that access to land in the new segment. Random stack-flagged writes are mixed in while S is non-zero, to show that they never disturb S or the other segments.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
  // Destination of one CPU data access after translation
  typedef enum logic [1:0] {
    TGT_VOID = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_REG  = 2'd2,
    TGT_IO   = 2'd3
  } target_e;
endpackage

// File: rtl/segmap_decode.sv
module segmap_decode
  import segmap_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SEG_W      = 8,
  parameter int SEG_COUNT  = 4,
  parameter int SEG0_LIMIT = 'h70,
  parameter int REG_BASE   = 'hF0,
  localparam int OFS_W     = ADDR_W - 1,
  localparam int SEG_IDX_W = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
  localparam int RAM_AW    = SEG_IDX_W + OFS_W,
  localparam int REG_N     = (1 << ADDR_W) - REG_BASE,
  localparam int REG_IW    = (REG_N > 1) ? $clog2(REG_N) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              stack,
  input  logic [SEG_W-1:0]  seg_reg,
  output target_e           target,
  output logic [RAM_AW-1:0] ram_idx,
  output logic [REG_IW-1:0] reg_idx
);
  logic [SEG_W-1:0] seg_eff;
  logic             seg_empty;
  logic             seg0_hole;

  // stack traffic is pinned to segment 0
  assign seg_eff   = stack ? '0 : seg_reg;
  assign seg_empty = int'(seg_eff) >= SEG_COUNT;
  assign seg0_hole = (seg_eff == '0) && (int'(addr[OFS_W-1:0]) >= SEG0_LIMIT);
  assign ram_idx   = {seg_eff[SEG_IDX_W-1:0], addr[OFS_W-1:0]};
  assign reg_idx   = addr[REG_IW-1:0];

  always_comb begin
    if (addr[ADDR_W-1]) begin
      target = (int'(addr) >= REG_BASE) ? TGT_REG : TGT_IO;
    end else if (seg_empty || seg0_hole) begin
      target = TGT_VOID;
    end else begin
      target = TGT_RAM;
    end
  end
endmodule

// File: rtl/segmap_regbank.sv
module segmap_regbank #(
  parameter int DATA_W   = 8,
  parameter int REG_N    = 16,
  parameter int IDX_X    = 12,
  parameter int IDX_SP   = 13,
  parameter int IDX_B    = 14,
  parameter int IDX_S    = 15,
  parameter int SP_RESET = 'h6F,
  localparam int REG_IW  = (REG_N > 1) ? $clog2(REG_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [REG_IW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] seg_val
);
  logic [REG_N*DATA_W-1:0] bank_flat;

  for (genvar i = 0; i < REG_N; i++) begin : g_byte
    logic hit;
    logic [DATA_W-1:0] byte_q;
    assign hit = we && (int'(idx) == i);
    if (i == IDX_X || i == IDX_SP || i == IDX_B || i == IDX_S) begin : g_ptr
      localparam logic [DATA_W-1:0] RST_VAL = (i == IDX_SP) ? DATA_W'(SP_RESET) : '0;
      always_ff @(posedge clk) begin
        if (rst)      byte_q <= RST_VAL;
        else if (hit) byte_q <= wdata;
      end
    end else begin : g_gen
      always_ff @(posedge clk) begin
        if (hit) byte_q <= wdata;
      end
    end
    assign bank_flat[i*DATA_W +: DATA_W] = byte_q;
  end

  // registered read, old contents when a write hits the same byte
  always_ff @(posedge clk) begin
    if (re) rdata <= bank_flat[idx*DATA_W +: DATA_W];
  end

  assign seg_val = bank_flat[IDX_S*DATA_W +: DATA_W];
endmodule

// File: rtl/segmap_ram.sv
module segmap_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-before-write, contents not reset
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/seg_mem_mapper.sv
module seg_mem_mapper
  import segmap_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SEG_COUNT  = 4,
  parameter int SEG0_LIMIT = 'h70,
  parameter int REG_BASE   = 'hF0,
  parameter int SP_RESET   = 'h6F,
  localparam int ADDR_W    = 8,
  localparam int OFS_W     = ADDR_W - 1,
  localparam int SEG_IDX_W = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
  localparam int RAM_AW    = SEG_IDX_W + OFS_W,
  localparam int RAM_DEPTH = 1 << RAM_AW,
  localparam int REG_N     = (1 << ADDR_W) - REG_BASE,
  localparam int REG_IW    = (REG_N > 1) ? $clog2(REG_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_stack,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] io_addr,
  output logic              io_rd,
  output logic              io_wr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata
);
  target_e           tgt;
  target_e           sel_q;
  logic [RAM_AW-1:0] ram_idx;
  logic [REG_IW-1:0] reg_idx;
  logic [DATA_W-1:0] s_val;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] io_q;

  segmap_decode #(
    .ADDR_W(ADDR_W), .SEG_W(DATA_W), .SEG_COUNT(SEG_COUNT),
    .SEG0_LIMIT(SEG0_LIMIT), .REG_BASE(REG_BASE)
  ) i_decode (
    .addr(cpu_addr), .stack(cpu_stack), .seg_reg(s_val),
    .target(tgt), .ram_idx(ram_idx), .reg_idx(reg_idx)
  );

  segmap_regbank #(
    .DATA_W(DATA_W), .REG_N(REG_N),
    .IDX_X(REG_N - 4), .IDX_SP(REG_N - 3), .IDX_B(REG_N - 2), .IDX_S(REG_N - 1),
    .SP_RESET(SP_RESET)
  ) i_regbank (
    .clk(clk), .rst(rst),
    .we(cpu_wr && tgt == TGT_REG), .re(cpu_rd && tgt == TGT_REG),
    .idx(reg_idx), .wdata(cpu_wdata), .rdata(reg_q), .seg_val(s_val)
  );

  segmap_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) i_ram (
    .clk(clk),
    .we(cpu_wr && tgt == TGT_RAM), .re(cpu_rd && tgt == TGT_RAM),
    .idx(ram_idx), .wdata(cpu_wdata), .rdata(ram_q)
  );

  assign io_addr  = cpu_addr;
  assign io_wdata = cpu_wdata;
  assign io_rd    = cpu_rd && (tgt == TGT_IO);
  assign io_wr    = cpu_wr && (tgt == TGT_IO);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= TGT_VOID;
      io_q  <= '0;
    end else if (cpu_rd) begin
      sel_q <= tgt;
      if (tgt == TGT_IO) io_q <= io_rdata;
    end
  end

  always_comb begin
    unique case (sel_q)
      TGT_RAM: cpu_rdata = ram_q;
      TGT_REG: cpu_rdata = reg_q;
      TGT_IO:  cpu_rdata = io_q;
      default: cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/segmap_checker.sv
module segmap_checker #(
  parameter int SEG_COUNT = 4
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cpu_addr,
  input logic       cpu_rd,
  input logic       cpu_wr,
  input logic       cpu_stack,
  input logic [7:0] cpu_rdata,
  input logic       io_rd,
  input logic       io_wr,
  input logic [7:0] seg_q
);
  // R8
  io_range_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd || io_wr) |-> (cpu_addr[7] && cpu_addr[7:4] != 4'hF));

  // R8
  io_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[7] && cpu_addr[7:4] != 4'hF) |-> io_rd);

  // R5
  seg0_hole_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_stack && cpu_addr[7:4] == 4'h7) |=> (cpu_rdata == 8'h00));

  // R6
  empty_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_stack && !cpu_addr[7] && int'(seg_q) >= SEG_COUNT) |=> (cpu_rdata == 8'h00));

  // R3
  seg_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr == 8'hFF) |=> $stable(seg_q));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));
endmodule

bind seg_mem_mapper segmap_checker #(.SEG_COUNT(SEG_COUNT)) i_segmap_checker (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_stack(cpu_stack), .cpu_rdata(cpu_rdata), .io_rd(io_rd), .io_wr(io_wr),
  .seg_q(s_val)
);

// File: tb/test_seg_mem_mapper.sv
module test_seg_mem_mapper;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cpu_addr = '0;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_stack = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata, io_addr, io_wdata, io_rdata;
  logic       io_rd, io_wr;

  int checks = 0, fails = 0;
  logic [7:0] m_ram [512];
  logic [7:0] m_reg [16];
  logic [7:0] io_last_a = '0, io_last_d = '0;

  always #(CLK_NS/2) clk = ~clk;
  assign io_rdata = io_addr ^ 8'h5A;

  always @(posedge clk) if (io_wr) begin
    io_last_a <= io_addr;
    io_last_d <= io_wdata;
  end

  seg_mem_mapper i_seg_mem_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_stack(cpu_stack), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] seg_of(logic stk);
    return stk ? 8'h00 : m_reg[15];
  endfunction

  function automatic bit populated(logic [7:0] a, logic stk);
    logic [7:0] s = seg_of(stk);
    return !(s >= 8'd4 || (s == 8'd0 && a[6:0] >= 7'h70));
  endfunction

  function automatic logic [7:0] ref_read(logic [7:0] a, logic stk);
    if (a[7]) return (a >= 8'hF0) ? m_reg[a[3:0]] : (a ^ 8'h5A);
    if (!populated(a, stk)) return 8'h00;
    return m_ram[{seg_of(stk)[1:0], a[6:0]}];
  endfunction

  task automatic ref_write(logic [7:0] a, logic [7:0] d, logic stk);
    if (a[7]) begin
      if (a >= 8'hF0) m_reg[a[3:0]] = d;
    end else if (populated(a, stk)) begin
      m_ram[{seg_of(stk)[1:0], a[6:0]}] = d;
    end
  endtask

  function automatic string tag_of(logic [7:0] a, logic stk);
    if (a[7]) return (a >= 8'hF0) ? "R1" : "R8";
    if (stk) return "R7";
    if (m_reg[15] >= 8'd4) return "R6";
    if (m_reg[15] == 8'd0 && a[6:0] >= 7'h70) return "R5";
    return "R2";
  endfunction

  // one cycle: drive at negedge, check read data at the next negedge
  task automatic op(bit rd, bit wr, logic [7:0] a, logic [7:0] d, bit stk, string req);
    logic [7:0] exp = ref_read(a, stk);
    bit is_io = a[7] && a < 8'hF0;
    cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr; cpu_stack = stk;
    #1;
    if (rd || wr) check("R8", {7'b0, io_rd | io_wr}, {7'b0, is_io});
    @(negedge clk);
    if (wr) ref_write(a, d, stk);
    if (rd) check(req, cpu_rdata, exp);
    if (wr && is_io) begin
      check("R8", io_last_a, a);
      check("R8", io_last_d, d);
    end
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_stack = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    summary();
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED_1234));
    m_reg[12] = 8'h00; m_reg[13] = 8'h6F; m_reg[14] = 8'h00; m_reg[15] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4 reset state
    check("R4", cpu_rdata, 8'h00);
    op(1, 0, 8'hFC, 0, 0, "R4");
    op(1, 0, 8'hFD, 0, 0, "R4");
    op(1, 0, 8'hFE, 0, 0, "R4");
    op(1, 0, 8'hFF, 0, 0, "R4");

    // fill the register bank and all populated segments, plus two empty ones
    for (int r = 0; r < 15; r++) op(0, 1, 8'hF0 + 8'(r), 8'(r * 11 + 3), 0, "R1");
    for (int s = 0; s < 6; s++) begin
      op(0, 1, 8'hFF, 8'(s), 0, "R3");
      for (int o = 0; o < 128; o++) op(0, 1, 8'(o), 8'(s * 37 + o * 3 + 1), 0, "R2");
    end

    // R6 empty segment: read zero, no alias
    op(1, 0, 8'h10, 0, 0, "R6");
    op(0, 1, 8'hFF, 8'd0, 0, "R3");
    op(1, 0, 8'h10, 0, 0, "R6");
    // R5 hole in segment 0
    op(1, 0, 8'h75, 0, 0, "R5");
    // R3 relocation takes effect on the very next access
    op(0, 1, 8'hFF, 8'd2, 0, "R3");
    op(1, 0, 8'h05, 0, 0, "R3");
    op(0, 1, 8'hFF, 8'd3, 0, "R3");
    op(1, 0, 8'h05, 0, 0, "R3");
    // R1 register byte independent of S
    op(1, 0, 8'hF4, 0, 0, "R1");
    // R7 stack flag forces segment 0 and leaves S alone
    op(0, 1, 8'h20, 8'hC3, 1, "R7");
    op(1, 0, 8'h20, 0, 1, "R7");
    op(1, 0, 8'h20, 0, 0, "R7");
    op(1, 0, 8'hFF, 0, 0, "R7");
    // R10 simultaneous read and write
    op(0, 1, 8'hFF, 8'd1, 0, "R3");
    op(1, 1, 8'h05, 8'h22, 0, "R10");
    op(1, 0, 8'h05, 0, 0, "R10");
    op(1, 1, 8'hF2, 8'h99, 0, "R10");
    op(1, 0, 8'hF2, 0, 0, "R10");
    // R8 I/O read and write
    op(1, 0, 8'h80, 0, 0, "R8");
    op(0, 1, 8'hEF, 8'h6C, 0, "R8");
    // R9 hold across idle cycles
    op(1, 0, 8'h05, 0, 0, "R9");
    held = cpu_rdata;
    op(0, 0, 8'h33, 0, 0, "R9");
    check("R9", cpu_rdata, held);
    op(0, 1, 8'h06, 8'h44, 0, "R9");
    check("R9", cpu_rdata, held);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a = 8'($urandom());
      logic [7:0] d = 8'($urandom());
      bit stk = ($urandom() % 4) == 0;
      bit rd = 1'($urandom());
      bit wr = 1'($urandom());
      if (($urandom() % 10) == 0) a = 8'hFF;
      if (a == 8'hFF) d = 8'($urandom_range(0, 5));
      op(rd, wr, a, d, stk, (rd && wr) ? "R10" : tag_of(a, stk));
    end
    summary();
  end
endmodule